// File: doc/BRIEF.md
# Switch Register Access Bridge

This block gives a host processor access to the register space of an on-chip packet switch. On the host side it is a small 32-bit register bus. It decodes a few word offsets into an ownership control word, a command word, a pair of write-data words and a pair of read-data words. On the switch side it drives a single-outstanding register port. That port carries a request, a write flag, an 8-bit page, an 8-bit register number and 64 bits of write data. It takes back 64 bits of read data and a one-cycle done pulse.

Before issuing a command, the host must gain ownership. It sets the request bit in the control word and waits for the bridge to return the grant bit. The grant is only given while no internal agent holds the port. The host then loads the write-data words, if the operation is a write, and writes the command word with its go bit set. The go bit reads back as one while the switch access is in flight, so it serves as the busy flag. It clears when the switch answers, or after a bounded timeout. Transfers of 8, 16, 32, 48 and 64 bits all use the same path: narrow values sit in the low bits of the low word, and a 48-bit value uses the low 16 bits of the high word. The host releases ownership by clearing its request bit.

Top module: `sw_reg_bridge`

## Requirements
- R1: After reset, the control word reads zero except for bit 6, which mirrors `sw_init_done`. The command word and both read-data words read zero, and `sw_req` is low.
- R2: The control word at offset 0x40 holds the host request in bit 3 and the grant in bit 4. The grant rises one clock after the stored request is seen, but only if `int_busy` is low. It falls one clock after the stored request is cleared. It never rises while `int_busy` is high.
- R3: A write to the command word at offset 0x2C while the grant is low has no effect: the go bit (bit 0) stays clear and `sw_req` stays low.
- R4: A command write with the grant held and bit 0 set starts an operation in the same clock. From then on, `sw_req` is high and bit 0 reads 1. `sw_page` and `sw_reg` carry bits 31:24 and 23:16 of the command. `sw_write` carries bit 1 (1 is a write, 0 is a read). `sw_wdata` carries the high write word (0x30) above the low write word (0x34).
- R5: On the clock where `sw_done` is high during an operation, the go bit clears and `sw_req` drops. For a read, both read-data words (0x38 high, 0x3C low) take `sw_rdata` together on that same clock.
- R6: A write operation leaves both read-data words unchanged.
- R7: Host writes to offsets 0x38 and 0x3C have no effect. Reads of any unmapped offset return zero.
- R8: If `sw_done` has not arrived after TMO_CYCLES clocks of busy, the go bit clears and `sw_req` drops. The read-data words are left unchanged.
- R9: A command write with bit 2 set, made while the grant is held, aborts any operation in flight. It clears the go bit, drops `sw_req` and zeroes both read-data words. Bit 2 always reads 0.
- R10: A command write during an operation that does not have bit 2 set is ignored: the page, the register and the go bit keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_addr | input | 8 | Host byte offset |
| hb_we | input | 1 | Host write strobe |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data (combinational on hb_addr) |
| int_busy | input | 1 | An internal agent owns the switch port |
| sw_init_done | input | 1 | Switch initialisation complete |
| sw_req | output | 1 | Switch access in flight |
| sw_write | output | 1 | Access is a write |
| sw_page | output | 8 | Switch page number |
| sw_reg | output | 8 | Switch register number |
| sw_wdata | output | 64 | Write data to the switch |
| sw_rdata | input | 64 | Read data from the switch |
| sw_done | input | 1 | One-cycle completion pulse |

## Verification
Host writes are driven at a falling edge and take effect at the next rising edge. Reads are combinational, so each state check samples at the falling edge after the edge that is due to change the state. The grant is checked once at the falling edge right after the request is captured, where it must still be low, and again one clock later, where it must be high. Completion is polled each falling edge, and the read-data words are compared in the very sample where the go bit first reads 0, which checks that both words move on the completion clock. The timeout test counts exactly TMO_CYCLES-1 clocks of busy and then one more clock to the clear.

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge #(
  parameter int AW = 8,
  parameter int TMO_CYCLES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] hb_addr,
  input  logic          hb_we,
  input  logic [31:0]   hb_wdata,
  output logic [31:0]   hb_rdata,
  input  logic          int_busy,
  input  logic          sw_init_done,
  output logic          sw_req,
  output logic          sw_write,
  output logic [7:0]    sw_page,
  output logic [7:0]    sw_reg,
  output logic [63:0]   sw_wdata,
  input  logic [63:0]   sw_rdata,
  input  logic          sw_done
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [AW-1:0] A_CMD  = AW'(8'h2C);
  localparam logic [AW-1:0] A_WDH  = AW'(8'h30);
  localparam logic [AW-1:0] A_WDL  = AW'(8'h34);
  localparam logic [AW-1:0] A_RDH  = AW'(8'h38);
  localparam logic [AW-1:0] A_RDL  = AW'(8'h3C);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h40);

  logic          req_q, grant_q, busy_q, wr_q;
  logic [7:0]    page_q, reg_q;
  logic [31:0]   wd_hi, wd_lo, rd_hi, rd_lo;
  logic [TW-1:0] tmo_q;

  wire cmd_hit  = hb_we && (hb_addr == A_CMD);
  wire abort    = cmd_hit && grant_q && hb_wdata[2];
  wire start_ok = cmd_hit && grant_q && !busy_q && !hb_wdata[2];
  wire finish   = busy_q && sw_done;
  wire expire   = busy_q && !sw_done && (tmo_q == TW'(TMO_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      grant_q <= 1'b0;
      wd_hi   <= '0;
      wd_lo   <= '0;
    end else begin
      if (hb_we && hb_addr == A_CTRL) req_q <= hb_wdata[3];
      if (hb_we && hb_addr == A_WDH)  wd_hi <= hb_wdata;
      if (hb_we && hb_addr == A_WDL)  wd_lo <= hb_wdata;
      grant_q <= req_q && (grant_q || !int_busy);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      page_q <= '0;
      reg_q  <= '0;
      tmo_q  <= '0;
      rd_hi  <= '0;
      rd_lo  <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      tmo_q  <= '0;
      rd_hi  <= '0;
      rd_lo  <= '0;
    end else if (start_ok) begin
      busy_q <= hb_wdata[0];
      wr_q   <= hb_wdata[1];
      page_q <= hb_wdata[31:24];
      reg_q  <= hb_wdata[23:16];
      tmo_q  <= '0;
    end else if (finish) begin
      busy_q <= 1'b0;
      tmo_q  <= '0;
      if (!wr_q) begin
        rd_hi <= sw_rdata[63:32];
        rd_lo <= sw_rdata[31:0];
      end
    end else if (expire) begin
      busy_q <= 1'b0;
      tmo_q  <= '0;
    end else if (busy_q) begin
      tmo_q  <= tmo_q + 1'b1;
    end
  end

  assign sw_req   = busy_q;
  assign sw_write = wr_q;
  assign sw_page  = page_q;
  assign sw_reg   = reg_q;
  assign sw_wdata = {wd_hi, wd_lo};

  always_comb begin
    case (hb_addr)
      A_CMD:   hb_rdata = {page_q, reg_q, 13'b0, 1'b0, wr_q, busy_q};
      A_WDH:   hb_rdata = wd_hi;
      A_WDL:   hb_rdata = wd_lo;
      A_RDH:   hb_rdata = rd_hi;
      A_RDL:   hb_rdata = rd_lo;
      A_CTRL:  hb_rdata = {25'b0, sw_init_done, 1'b0, grant_q, req_q, 3'b0};
      default: hb_rdata = '0;
    endcase
  end

  // R2
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_q) |-> ($past(req_q) && !$past(int_busy)));
  // R2
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q |=> !grant_q);
  // R3
  cmd_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && !grant_q && !busy_q) |=> !sw_req);
  // R5
  done_clears_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_done) |=> !sw_req);
  // R6
  rd_words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sw_req && sw_done && !sw_write) && !abort) |=> $stable({rd_hi, rd_lo}));
  // R8
  timeout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> (tmo_q < TW'(TMO_CYCLES)));
  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!sw_req && rd_hi == 32'h0 && rd_lo == 32'h0));
endmodule

// File: tb/sw_reg_bridge_tb.sv
module sw_reg_bridge_tb;
  localparam int TMO = 32;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  hb_addr = '0;
  logic        hb_we = 1'b0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata;
  logic        int_busy = 1'b0;
  logic        sw_init_done = 1'b0;
  logic        sw_req, sw_write;
  logic [7:0]  sw_page, sw_reg;
  logic [63:0] sw_wdata, sw_rdata;
  logic        sw_done;

  int total = 0;
  int bad = 0;
  logic        resp_en = 1'b1;
  logic [63:0] mem [4];
  int          rcnt;
  logic [7:0]  lw_page, lw_reg;
  logic [63:0] lw_data;

  always #2 clk = ~clk;

  sw_reg_bridge #(.AW(8), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_we(hb_we),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .int_busy(int_busy),
    .sw_init_done(sw_init_done), .sw_req(sw_req), .sw_write(sw_write),
    .sw_page(sw_page), .sw_reg(sw_reg), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .sw_done(sw_done));

  assign sw_rdata = mem[sw_reg[1:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      sw_done <= 1'b0;
      rcnt    <= 0;
    end else if (sw_req && !sw_done && resp_en) begin
      if (rcnt == LAT) begin
        sw_done <= 1'b1;
        rcnt    <= 0;
        if (sw_write) begin
          mem[sw_reg[1:0]] <= sw_wdata;
          lw_page <= sw_page;
          lw_reg  <= sw_reg;
          lw_data <= sw_wdata;
        end
      end else rcnt <= rcnt + 1;
    end else begin
      sw_done <= 1'b0;
      rcnt    <= 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hb_addr = a; hb_wdata = d; hb_we = 1'b1;
    @(negedge clk);
    hb_we = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    hb_addr = a;
    #1;
    d = hb_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    hread(8'h40, v); chk("R1 ctrl", 64'(v), 64'h0);
    hread(8'h2C, v); chk("R1 cmd", 64'(v), 64'h0);
    hread(8'h38, v); chk("R1 rd_hi", 64'(v), 64'h0);
    hread(8'h3C, v); chk("R1 rd_lo", 64'(v), 64'h0);
    chk("R1 sw_req", 64'(sw_req), 64'h0);
    sw_init_done = 1'b1;
    hread(8'h40, v); chk("R1 init_done bit6", 64'(v), 64'h40);
  endtask

  task automatic t_nogrant;
    logic [31:0] v;
    hwrite(8'h2C, 32'h0102_0001);
    hread(8'h2C, v); chk("R3 go stays clear", 64'(v[0]), 64'h0);
    chk("R3 sw_req low", 64'(sw_req), 64'h0);
  endtask

  task automatic t_grant;
    logic [31:0] v;
    int_busy = 1'b1;
    hwrite(8'h40, 32'h8);
    repeat (3) @(negedge clk);
    hread(8'h40, v); chk("R2 blocked by int_busy", 64'(v[4:3]), 64'h1);
    int_busy = 1'b0;
    @(negedge clk);
    hread(8'h40, v); chk("R2 grant after int_busy", 64'(v[4]), 64'h1);
    hwrite(8'h40, 32'h0);
    hread(8'h40, v); chk("R2 grant one clock after clear", 64'(v[4]), 64'h1);
    @(negedge clk);
    hread(8'h40, v); chk("R2 grant released", 64'(v[4]), 64'h0);
    hwrite(8'h40, 32'h8);
    hread(8'h40, v); chk("R2 not yet granted", 64'(v[4]), 64'h0);
    @(negedge clk);
    hread(8'h40, v); chk("R2 granted", 64'(v[4]), 64'h1);
  endtask

  task automatic run_op(input string tag, input logic wr, input logic [7:0] pg,
                        input logic [7:0] rg, input logic [63:0] wd,
                        input logic [63:0] exp_rd);
    logic [31:0] v, h, l;
    hwrite(8'h30, wd[63:32]);
    hwrite(8'h34, wd[31:0]);
    hwrite(8'h2C, {pg, rg, 14'h0, wr, 1'b1});
    hread(8'h2C, v); chk({"R4 busy ", tag}, 64'(v[0]), 64'h1);
    chk({"R4 sw_req ", tag}, 64'(sw_req), 64'h1);
    chk({"R4 fields ", tag}, {46'h0, sw_write, sw_page, sw_reg}, {46'h0, wr, pg, rg});
    chk({"R4 sw_wdata ", tag}, sw_wdata, wd);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      hread(8'h2C, v);
      if (!v[0]) break;
    end
    chk({"R5 go cleared ", tag}, 64'(v[0]), 64'h0);
    chk({"R5 sw_req dropped ", tag}, 64'(sw_req), 64'h0);
    hread(8'h38, h); hread(8'h3C, l);
    chk({"R5/R6 rd words ", tag}, {h, l}, exp_rd);
  endtask

  task automatic t_ops;
    logic [31:0] h, l;
    run_op("read1", 1'b0, 8'h12, 8'h01, 64'h0, mem[1]);
    run_op("write2", 1'b1, 8'hA0, 8'h02, 64'h0000_BEEF_1234_5678, mem[1]);
    chk("R4 switch saw write", {40'h0, lw_page, lw_reg, 8'h0}, {40'h0, 8'hA0, 8'h02, 8'h0});
    chk("R4 switch write data", lw_data, 64'h0000_BEEF_1234_5678);
    run_op("read2", 1'b0, 8'hA0, 8'h02, 64'h0, 64'h0000_BEEF_1234_5678);
    hwrite(8'h38, 32'hFFFF_FFFF);
    hwrite(8'h3C, 32'hFFFF_FFFF);
    hread(8'h38, h); hread(8'h3C, l);
    chk("R7 rd words ignore writes", {h, l}, 64'h0000_BEEF_1234_5678);
    hread(8'h10, h); chk("R7 unmapped 0x10", 64'(h), 64'h0);
    hread(8'h44, h); chk("R7 unmapped 0x44", 64'(h), 64'h0);
  endtask

  task automatic t_timeout;
    logic [31:0] v, h, l;
    resp_en = 1'b0;
    hwrite(8'h2C, 32'h0503_0001);
    repeat (TMO - 1) @(negedge clk);
    hread(8'h2C, v); chk("R8 still busy before limit", 64'(v[0]), 64'h1);
    @(negedge clk);
    hread(8'h2C, v); chk("R8 go cleared at limit", 64'(v[0]), 64'h0);
    chk("R8 sw_req dropped", 64'(sw_req), 64'h0);
    hread(8'h38, h); hread(8'h3C, l);
    chk("R8 rd words kept", {h, l}, 64'h0000_BEEF_1234_5678);
  endtask

  task automatic t_abort;
    logic [31:0] v, h, l;
    hwrite(8'h2C, 32'h0703_0001);
    hwrite(8'h2C, 32'h0900_0001);
    hread(8'h2C, v); chk("R10 cmd during busy ignored", 64'(v), 64'h0703_0001);
    hwrite(8'h2C, 32'h0000_0004);
    hread(8'h2C, v); chk("R9 abort clears go, bit2 reads 0", 64'(v[2:0]), 64'h0);
    chk("R9 sw_req dropped", 64'(sw_req), 64'h0);
    hread(8'h38, h); hread(8'h3C, l);
    chk("R9 rd words zeroed", {h, l}, 64'h0);
    resp_en = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = 64'h0101_0202_0303_0404 * 64'(i + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_nogrant;
    t_grant;
    t_ops;
    t_timeout;
    t_abort;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule